// File: doc/BRIEF.md
# Master Serial Configuration Loader

This block sits in the device being configured and pulls its configuration stream out of an external bit-serial ROM. Once the restart input is released it holds the ROM's reset low for a short settling time and reads the three mode inputs. If all three are zero it starts a divided configuration clock and takes one bit from the ROM's data line on each rising edge of that clock. It first checks a header made of a run of ones, a fixed 4-bit sync word and a 24-bit length field sent most significant bit first. It then passes the payload bits out one at a time. When the configuration clock has risen as many times as the length field gives, it raises `done`. `done` drives the ROM's chip enable, so the ROM stops advancing. One clock later the loader enables user I/O and stops the clock.

The control is one state machine. RESET follows reset or a low restart input and goes to CLEAR. CLEAR holds the ROM in reset for `CLR_CYC` cycles, then goes to LEADIN when the mode is all zero, or to NOTMASTER otherwise. LEADIN counts ones. A zero goes to SYNC, or to ERROR when too few ones came before it. SYNC goes to LENGTH on a matching sync word and to ERROR on a mismatch. LENGTH goes to PAYLOAD, or to ERROR when the length cannot cover the header. PAYLOAD goes to DONE on the last counted edge. DONE goes to USER on the next edge. USER, NOTMASTER and ERROR wait. A low restart input sends every state back to RESET.

Top module: `cfg_serial_loader`

## Requirements
- R1: While reset or `prog_n` is low, `init_n`, `cclk`, `done`, `user_en`, `cfg_err` and `bit_vld` are all low, and no configuration clock edge occurs.
- R2: After `prog_n` goes high, `init_n` stays low for exactly `CLR_CYC`+1 system cycles. The mode inputs are then sampled.
- R3: A mode value other than all-zero (for example 3'b100) produces no configuration clock, keeps `init_n` high and keeps `done`, `user_en` and `cfg_err` low until the next restart.
- R4: Rising edges of `cclk` are spaced exactly 2·`HALF_DIV` system cycles apart. Stream bit k (0-based, the ROM's address after k increments) is taken at the edge on which `cclk` makes its (k+1)-th rise.
- R5: The header must open with at least `MIN_ONES` ones and be followed by the sync word 4'b0010 (first bit sent is the MSB). With fewer ones or a wrong word, `cfg_err` rises and `init_n` falls in the cycle after the rise that took the offending bit, and `cclk` stops.
- R6: The 24 bits after the sync word form the length L, received MSB first. L counts `cclk` rises from the first rise of the load, header included.
- R7: Each bit after the length field up to and including rise L appears on `bit_out`, with `bit_vld` high for one cycle. This happens in the cycle after its rise, in stream order.
- R8: `done` rises in the cycle after the L-th rise. The ROM then sees no further enabled clock edge, so its address ends at L.
- R9: Exactly one more `cclk` rise follows `done`. With it `user_en` rises, and no further `cclk` rise occurs.
- R10: If L is not greater than the number of header rises (ones + 4 + 24), the load ends in the error state at the last length bit, without `done`.
- R11: `prog_n` low in any state aborts the load and returns to the R1 state, including after `done`. The next load starts from ROM address zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | MODE_W | Mode inputs; all zero selects the master serial load |
| prog_n | input | 1 | Active-low restart; low aborts, its release starts a new load |
| rom_data | input | 1 | Serial data from the ROM |
| cclk | output | 1 | Generated configuration clock to the ROM |
| init_n | output | 1 | Active-low ROM reset; low during settling and on error |
| done | output | 1 | Configuration finished; drives the ROM's chip enable (high disables) |
| user_en | output | 1 | User I/O enable, one configuration clock after `done` |
| cfg_err | output | 1 | Header or length fault; cleared by restart |
| bit_out | output | 1 | Payload bit |
| bit_vld | output | 1 | One-cycle strobe qualifying `bit_out` |

## Verification
Every result is tied to a `cclk` rise, and the bench counts rises at falling system-clock edges. The ones that appear on the sampling edge of a rise are `done` at rise L, `user_en` at rise L+1 and `cfg_err` at the rise that took the bad bit. Each of these is checked as an exact rise number rather than waited for loosely. The settling time of `init_n` is counted in sampled cycles and compared with `CLR_CYC`+1. Payload bits, which follow their rise by one cycle, are compared in order against the image the bench built. The ROM address the bench's ROM model reaches, and the total rise count some cycles after the end, confirm that the ROM and the clock stop where required.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_CLEAR,
        ST_LEADIN,
        ST_SYNC,
        ST_LENGTH,
        ST_PAYLOAD,
        ST_DONE,
        ST_USER,
        ST_NOTMASTER,
        ST_ERROR
    } cfgl_state_e;

endpackage

// File: rtl/cfgl_clkgen.sv
module cfgl_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic cclk,
    output logic rise_stb
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] TERM = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          cclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cclk_q <= 1'b0;
        end else if (!run) begin
            cnt_q  <= '0;
            cclk_q <= 1'b0;
        end else if (cnt_q == TERM) begin
            cnt_q  <= '0;
            cclk_q <= ~cclk_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The edge that lifts cclk is the edge on which the stream bit is taken.
    assign rise_stb = run && !cclk_q && (cnt_q == TERM);
    assign cclk     = cclk_q;

    // R4: the generated clock parks low once it is no longer wanted
    p_clock_parks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !cclk_q);

endmodule

// File: rtl/cfgl_count.sv
module cfgl_count #(
    parameter int LEN_W = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic shift_en,
    input  logic din,
    output logic len_short,
    output logic last_edge
);
    localparam int EW = LEN_W + 1;
    localparam logic [EW-1:0] EMAX = '1;

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_nxt;
    logic [EW-1:0]    edges_q;
    logic [EW-1:0]    edges_nxt;

    assign len_nxt   = {len_q[LEN_W-2:0], din};
    assign edges_nxt = edges_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            edges_q <= '0;
        end else if (clr) begin
            len_q   <= '0;
            edges_q <= '0;
        end else begin
            if (stb && edges_q != EMAX) edges_q <= edges_nxt;
            if (stb && shift_en)        len_q   <= len_nxt;
        end
    end

    // Evaluated on the last length bit: the new length must exceed the header.
    assign len_short = ({1'b0, len_nxt} <= edges_nxt);
    // The current rise is the L-th one of the load.
    assign last_edge = stb && (edges_nxt == {1'b0, len_q});

    // R6: the length field only moves while it is being received
    p_len_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !clr) |=> $stable(len_q));

endmodule

// File: rtl/cfgl_fsm.sv
module cfgl_fsm
    import cfgl_pkg::*;
#(
    parameter int              CLR_CYC  = 4,
    parameter int              MIN_ONES = 4,
    parameter int              SYNC_W   = 4,
    parameter logic [SYNC_W-1:0] SYNC_PAT = 4'b0010,
    parameter int              LEN_W    = 24,
    parameter int              MODE_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              stb,
    input  logic              din,
    input  logic              len_short,
    input  logic              last_edge,
    output cfgl_state_e       state_o,
    output logic              run,
    output logic              cnt_clr,
    output logic              len_shift,
    output logic              init_n,
    output logic              done,
    output logic              user_en,
    output logic              cfg_err,
    output logic              bit_out,
    output logic              bit_vld
);
    localparam int FW = $clog2(LEN_W + CLR_CYC + MIN_ONES + SYNC_W + 1);

    cfgl_state_e       state_q, state_n;
    logic [FW-1:0]     fld_q, fld_n;
    logic [SYNC_W-1:0] sync_q, sync_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
            fld_q   <= '0;
            sync_q  <= '0;
        end else begin
            state_q <= state_n;
            fld_q   <= fld_n;
            sync_q  <= sync_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state_q;
        fld_n   = fld_q;
        sync_n  = sync_q;
        if (!prog_n) begin
            state_n = ST_RESET;
            fld_n   = '0;
        end else begin
            unique case (state_q)
                ST_RESET: begin
                    state_n = ST_CLEAR;
                    fld_n   = '0;
                end
                ST_CLEAR: begin
                    if (fld_q == FW'(CLR_CYC - 1)) begin
                        fld_n   = '0;
                        state_n = (mode_sel == '0) ? ST_LEADIN : ST_NOTMASTER;
                    end else begin
                        fld_n = fld_q + 1'b1;
                    end
                end
                ST_LEADIN: begin
                    if (stb) begin
                        if (din) begin
                            if (fld_q < FW'(MIN_ONES)) fld_n = fld_q + 1'b1;
                        end else if (fld_q >= FW'(MIN_ONES)) begin
                            state_n = ST_SYNC;
                            fld_n   = FW'(1);
                            sync_n  = '0;
                        end else begin
                            state_n = ST_ERROR;
                        end
                    end
                end
                ST_SYNC: begin
                    if (stb) begin
                        sync_n = {sync_q[SYNC_W-2:0], din};
                        if (fld_q == FW'(SYNC_W - 1)) begin
                            fld_n   = '0;
                            state_n = (sync_n == SYNC_PAT) ? ST_LENGTH : ST_ERROR;
                        end else begin
                            fld_n = fld_q + 1'b1;
                        end
                    end
                end
                ST_LENGTH: begin
                    if (stb) begin
                        if (fld_q == FW'(LEN_W - 1)) begin
                            fld_n   = '0;
                            state_n = len_short ? ST_ERROR : ST_PAYLOAD;
                        end else begin
                            fld_n = fld_q + 1'b1;
                        end
                    end
                end
                ST_PAYLOAD: begin
                    if (last_edge) state_n = ST_DONE;
                end
                ST_DONE: begin
                    if (stb) state_n = ST_USER;
                end
                ST_USER, ST_NOTMASTER, ST_ERROR: begin
                    state_n = state_q;
                end
                default: state_n = ST_ERROR;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        init_n    = 1'b1;
        done      = 1'b0;
        user_en   = 1'b0;
        cfg_err   = 1'b0;
        run       = 1'b0;
        cnt_clr   = 1'b0;
        len_shift = 1'b0;
        unique case (state_q)
            ST_RESET, ST_CLEAR: begin
                init_n  = 1'b0;
                cnt_clr = 1'b1;
            end
            ST_LEADIN, ST_SYNC: run = 1'b1;
            ST_LENGTH: begin
                run       = 1'b1;
                len_shift = 1'b1;
            end
            ST_PAYLOAD: run = 1'b1;
            ST_DONE: begin
                run  = 1'b1;
                done = 1'b1;
            end
            ST_USER: begin
                done    = 1'b1;
                user_en = 1'b1;
            end
            ST_NOTMASTER: init_n = 1'b1;
            ST_ERROR: begin
                init_n  = 1'b0;
                cfg_err = 1'b1;
            end
            default: init_n = 1'b0;
        endcase
    end

    // Payload bit, presented in the cycle after its rise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_out <= 1'b0;
            bit_vld <= 1'b0;
        end else begin
            bit_vld <= prog_n && stb && (state_q == ST_PAYLOAD);
            if (stb) bit_out <= din;
        end
    end

    assign state_o = state_q;

    // R11: a low restart always lands in RESET
    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |=> state_q == ST_RESET);

    // R5: a fault is only ever raised by a consumed stream bit
    p_err_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(stb));

    // R9: a finished load stays finished until restart
    p_user_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_USER && prog_n) |=> state_q == ST_USER);

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfgl_pkg::*;
#(
    parameter int                HALF_DIV = 2,
    parameter int                CLR_CYC  = 4,
    parameter int                MIN_ONES = 4,
    parameter int                SYNC_W   = 4,
    parameter logic [SYNC_W-1:0] SYNC_PAT = 4'b0010,
    parameter int                LEN_W    = 24,
    parameter int                MODE_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              prog_n,
    input  logic              rom_data,
    output logic              cclk,
    output logic              init_n,
    output logic              done,
    output logic              user_en,
    output logic              cfg_err,
    output logic              bit_out,
    output logic              bit_vld
);
    cfgl_state_e st;
    logic        run, stb, cnt_clr, len_shift, len_short, last_edge;

    cfgl_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .cclk     (cclk),
        .rise_stb (stb)
    );

    cfgl_count #(.LEN_W(LEN_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .stb       (stb),
        .shift_en  (len_shift),
        .din       (rom_data),
        .len_short (len_short),
        .last_edge (last_edge)
    );

    cfgl_fsm #(
        .CLR_CYC  (CLR_CYC),
        .MIN_ONES (MIN_ONES),
        .SYNC_W   (SYNC_W),
        .SYNC_PAT (SYNC_PAT),
        .LEN_W    (LEN_W),
        .MODE_W   (MODE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_n    (prog_n),
        .mode_sel  (mode_sel),
        .stb       (stb),
        .din       (rom_data),
        .len_short (len_short),
        .last_edge (last_edge),
        .state_o   (st),
        .run       (run),
        .cnt_clr   (cnt_clr),
        .len_shift (len_shift),
        .init_n    (init_n),
        .done      (done),
        .user_en   (user_en),
        .cfg_err   (cfg_err),
        .bit_out   (bit_out),
        .bit_vld   (bit_vld)
    );

    // R8: completion is triggered only by the counted last edge
    p_done_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(last_edge));

    // R3: no clock while another mode is selected
    p_quiet_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_NOTMASTER) |-> !cclk);

    // R9: the clock is gone once user I/O is live
    p_user_noclk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_USER && $past(st == ST_USER)) |-> !cclk);

endmodule

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb;
    localparam int HALF = 2;
    localparam int CLR  = 4;
    localparam int LW   = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_n = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic       rom_data;
    logic       cclk, init_n, done, user_en, cfg_err, bit_out, bit_vld;

    always #4 clk = ~clk;

    cfg_serial_loader u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .prog_n   (prog_n),
        .rom_data (rom_data),
        .cclk     (cclk),
        .init_n   (init_n),
        .done     (done),
        .user_en  (user_en),
        .cfg_err  (cfg_err),
        .bit_out  (bit_out),
        .bit_vld  (bit_vld)
    );

    int ncheck = 0;
    int nbad   = 0;

    // ROM image and expected payload
    logic [511:0] img = '0;
    logic [511:0] pay = '0;

    // ROM model and monitor, both sampling at falling edges
    int   addr = 0;
    logic cclk_d = 1'b0, done_d = 1'b0, user_d = 1'b0, err_d = 1'b0;
    logic arm = 1'b0;
    int   rises = 0, done_at = -1, user_at = -1, err_at = -1;
    int   ngot = 0, nmis = 0, cyc = 0, last_cyc = 0, sp_min = 0, sp_max = 0;

    assign rom_data = done ? 1'b0 : img[addr[8:0]];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!init_n) addr = 0;
        else if (cclk && !cclk_d && !done_d) addr = addr + 1;
        if (arm) begin
            rises = 0; done_at = -1; user_at = -1; err_at = -1;
            ngot = 0; nmis = 0; sp_min = 1000000; sp_max = 0;
        end else begin
            if (cclk && !cclk_d) begin
                rises = rises + 1;
                if (rises > 1) begin
                    if (cyc - last_cyc < sp_min) sp_min = cyc - last_cyc;
                    if (cyc - last_cyc > sp_max) sp_max = cyc - last_cyc;
                end
                last_cyc = cyc;
            end
            if (done && !done_d)    done_at = rises;
            if (user_en && !user_d) user_at = rises;
            if (cfg_err && !err_d)  err_at  = rises;
            if (bit_vld) begin
                if (ngot < 512 && bit_out !== pay[ngot]) nmis = nmis + 1;
                ngot = ngot + 1;
            end
        end
        cclk_d = cclk; done_d = done; user_d = user_en; err_d = cfg_err;
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        ncheck++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic build(input int ones, input logic [3:0] pat, input int len,
                         input int np, input int seed);
        int idx = 0;
        img = '0;
        pay = '0;
        for (int i = 0; i < ones; i++) begin img[idx] = 1'b1; idx++; end
        for (int i = 3; i >= 0; i--) begin img[idx] = pat[i]; idx++; end
        for (int i = LW - 1; i >= 0; i--) begin img[idx] = len[i]; idx++; end
        for (int i = 0; i < np; i++) begin
            logic b;
            b = (((i * 5) + seed) % 7) < 3;
            img[idx] = b;
            pay[i]   = b;
            idx++;
        end
    endtask

    task automatic start(input logic [2:0] m);
        @(posedge clk); #1;
        mode_sel = m;
        arm      = 1'b1;
        prog_n   = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        arm    = 1'b0;
        prog_n = 1'b1;
    endtask

    task automatic wait_end(input string req);
        int n = 0;
        while (!(user_en || cfg_err) && n < 4000) begin
            @(posedge clk);
            n++;
        end
        repeat (20) @(posedge clk);
        #1;
        chk(n < 4000, req, "load never ended", n, 4000);
    endtask

    task automatic t_reset();
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        arm = 1'b1;
        @(posedge clk); #1 arm = 1'b0;
        repeat (20) @(posedge clk);
        #1;
        chk(init_n == 1'b0,  "R1", "init_n during restart", init_n, 0);
        chk(cclk == 1'b0,    "R1", "cclk during restart", cclk, 0);
        chk(done == 1'b0,    "R1", "done during restart", done, 0);
        chk(user_en == 1'b0, "R1", "user_en during restart", user_en, 0);
        chk(cfg_err == 1'b0 && bit_vld == 1'b0, "R1", "err/vld during restart",
            cfg_err, 0);
        chk(rises == 0,      "R1", "clock rises while held", rises, 0);
    endtask

    task automatic t_settle();
        int n = 0;
        build(8, 4'b0010, 56, 20, 1);
        start(3'b000);
        @(negedge clk);
        while (!init_n && n < 100) begin n++; @(negedge clk); end
        chk(n == CLR + 1, "R2", "init_n low cycles after release", n, CLR + 1);
        wait_end("R2");
    endtask

    task automatic t_normal(input int ones, input int len, input int np,
                            input int seed);
        build(ones, 4'b0010, len, np, seed);
        start(3'b000);
        wait_end("R8");
        chk(cfg_err == 1'b0, "R5", "error on valid header", cfg_err, 0);
        chk(done_at == len,  "R8", "rise count when done rose", done_at, len);
        chk(done_at == len,  "R6", "length taken MSB first", done_at, len);
        chk(addr == len,     "R8", "ROM address after done", addr, len);
        chk(user_at == len + 1, "R9", "rise count when user_en rose", user_at, len + 1);
        chk(rises == len + 1,   "R9", "total rises after finish", rises, len + 1);
        chk(ngot == np,      "R7", "payload bit count", ngot, np);
        chk(nmis == 0,       "R7", "payload mismatches", nmis, 0);
        chk(sp_min == 2 * HALF && sp_max == 2 * HALF, "R4", "rise spacing",
            sp_max, 2 * HALF);
    endtask

    task automatic t_mode();
        build(8, 4'b0010, 56, 20, 2);
        start(3'b100);
        repeat (200) @(posedge clk);
        #1;
        chk(rises == 0,    "R3", "rises in other mode", rises, 0);
        chk(init_n == 1'b1, "R3", "init_n in other mode", init_n, 1);
        chk(done == 1'b0 && user_en == 1'b0, "R3", "done in other mode", done, 0);
        chk(cfg_err == 1'b0, "R3", "error in other mode", cfg_err, 0);
    endtask

    task automatic t_fault(input string req, input int ones, input logic [3:0] pat,
                           input int len, input int exp_at);
        build(ones, pat, len, 4, 3);
        start(3'b000);
        wait_end(req);
        chk(cfg_err == 1'b1, req, "error flag", cfg_err, 1);
        chk(err_at == exp_at, req, "rise of error", err_at, exp_at);
        chk(init_n == 1'b0 && done == 1'b0, req, "init_n in error", init_n, 0);
        chk(rises == exp_at, req, "clock stopped in error", rises, exp_at);
    endtask

    task automatic t_restart_mid();
        int n = 0;
        build(8, 4'b0010, 56, 20, 4);
        start(3'b000);
        while (rises < 20 && n < 2000) begin @(posedge clk); n++; end
        #1 prog_n = 1'b0;
        @(posedge clk); #1;
        chk(init_n == 1'b0, "R11", "init_n after abort", init_n, 0);
        @(posedge clk); #1;
        chk(cclk == 1'b0, "R11", "cclk after abort", cclk, 0);
        @(posedge clk); #1;
        chk(addr == 0, "R11", "ROM address after abort", addr, 0);
        start(3'b000);
        wait_end("R11");
        chk(done_at == 56 && nmis == 0 && ngot == 20, "R11", "reload after abort",
            done_at, 56);
    endtask

    task automatic t_restart_done();
        #1 prog_n = 1'b0;
        @(posedge clk); #1;
        chk(done == 1'b0 && user_en == 1'b0, "R11", "done after restart", done, 0);
        chk(init_n == 1'b0, "R11", "init_n after restart", init_n, 0);
    endtask

    initial begin
        t_reset();
        t_settle();
        t_normal(8, 56, 20, 1);
        t_restart_done();
        t_normal(5, 200, 167, 5);
        t_mode();
        t_fault("R5", 6, 4'b0110, 60, 10);
        t_fault("R5", 3, 4'b0010, 60, 4);
        t_fault("R10", 8, 4'b0010, 36, 36);
        t_normal(8, 37, 1, 6);          // R10: one edge past the header is legal
        t_restart_mid();
        $display("  test done: total=%0d bad=%0d", ncheck, nbad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        ncheck++;
        nbad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", ncheck, nbad);
        $finish;
    end

endmodule